// File: doc/BRIEF.md
# Link Receive Sequence Checker

This block sits on the receive side of a reliable point-to-point link layer. Packets arrive as a stream of 32-bit beats. The first beat carries the packet's sequence number, the middle beats carry the payload, and the last beat carries a 32-bit CRC over every beat before it. The block checks the CRC and compares the sequence number with the one it expects next. It passes the payload of a good packet to the upper layer with the sequence and CRC beats removed. For every packet it judges, it can raise a request for an acknowledgement or a negative acknowledgement, and each request carries a sequence number.

Payload is held in a packet buffer until the CRC beat has been checked, so nothing reaches the upper layer before the packet is known to be good. Bad packets are discarded, and so is every packet after them, until the transmitter replays from the point that was named. A second NAK is held back until a good packet has been accepted again. Packets that are older than expected are treated as replays of data already received: they are dropped and answered with a fresh ACK. Sequence numbers are 12 bits wide and wrap modulo 4096.

Top module: `lld_rx_check`

## Requirements
- R1: A packet is the run of accepted beats from a beat with `in_sop` through a beat with `in_eop`. The sequence number is `in_data[11:0]` of the first beat, and the upper 20 bits of that beat are not compared. The beats strictly between the first and last are payload. The last beat must equal the CRC-32 of all earlier beats of the packet: reflected polynomial 0xEDB88320, register preset to all ones, each word fed least significant bit first, and the result inverted. The payload of a good packet leaves on `out_*` one word per cycle. It starts in the cycle after the last beat is accepted, `out_sop` marks the first word, `out_eop` marks the last word, and neither the sequence beat nor the CRC beat is sent.
- R2: A good packet has a correct CRC and carries exactly the expected sequence number. In the cycle after its last beat, `ack_valid` pulses for one cycle with `ack_is_nak`=0 and `ack_seq` equal to the packet's number. The expected number then advances by one modulo 4096, so 4095 is followed by 0.
- R3: A packet whose CRC check fails produces no output words and leaves the expected number unchanged. If NAKs are armed, it raises a one-cycle NAK (`ack_is_nak`=1) whose `ack_seq` is the last good number (expected − 1 mod 4096). Replay is requested from the number after that.
- R4: Let d = (seq − expected) mod 4096. When the CRC is correct and d lies in 1..2048, the packet is out of order and is handled as in R3. When the CRC is correct and (expected − seq) mod 4096 lies in 1..2047, the packet is a duplicate: it is dropped without output and answered with an ACK whose `ack_seq` is expected − 1. A duplicate does not change whether NAKs are armed.
- R5: Sending a NAK disarms NAKs. While they are disarmed, a bad or out-of-order packet raises no acknowledgement at all. The next good packet arms them again.
- R6: After reset the expected number is 0 and NAKs are armed, so the first NAK carries 4095. During reset, `out_valid` and `ack_valid` are 0 and `in_ready` is 1.
- R7: `in_ready` is 0 in every cycle that `out_valid` is 1. A beat is taken only in a cycle where `in_valid` and `in_ready` are both 1.
- R8: A packet with more than MAX_PAY payload beats, or a packet made of a single beat that has both `in_sop` and `in_eop`, is treated as a CRC failure.
- R9: A good packet with no payload beats produces its ACK and no output words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_sop | input | 1 | Beat is the first of a packet (sequence beat) |
| in_eop | input | 1 | Beat is the last of a packet (CRC beat) |
| in_data | input | 32 | Beat contents |
| in_ready | output | 1 | Block can take a beat this cycle |
| out_valid | output | 1 | Payload word to the upper layer |
| out_sop | output | 1 | First payload word of a packet |
| out_eop | output | 1 | Last payload word of a packet |
| out_data | output | 32 | Payload word |
| ack_valid | output | 1 | Acknowledgement request, one cycle |
| ack_is_nak | output | 1 | 1 = NAK, 0 = ACK |
| ack_seq | output | 12 | Sequence number carried by the request |

## Verification
The bench builds the block with MAX_PAY set to 4. With that value a five-word payload is enough to overflow the packet buffer, and a four-word payload fills it exactly. The sequence width stays at its default of 12 bits. A run of packets with no payload walks the expected number across the 4095-to-0 wrap in a few thousand packets, so both the wrap of the ACK number and a duplicate detected across the wrap are covered. A behavioural model that keeps queues of expected words and acknowledgements is compared with the outputs on every clock.

// File: rtl/lld_pkg.sv
// Package: shared types and the CRC step used by the link receive checker.
// Assumes 32-bit beats and the reflected CRC-32 polynomial.
package lld_pkg;

    localparam int          DW        = 32;
    localparam logic [31:0] CRC_POLY  = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED  = 32'hFFFF_FFFF;

    // Verdict given to a packet once its last beat is seen.
    typedef enum logic [1:0] {
        VER_GOOD = 2'd0,
        VER_DUP  = 2'd1,
        VER_BAD  = 2'd2
    } verdict_t;

    // Advances the CRC register over one 32-bit word, least significant bit first.
    function automatic logic [31:0] crc_step(input logic [31:0] crc_in, input logic [31:0] word);
        logic [31:0] c;
        logic        fb;
        c = crc_in;
        for (int i = 0; i < 32; i++) begin
            fb = c[0] ^ word[i];
            c  = {1'b0, c[31:1]};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/lld_crc.sv
// Running CRC-32 over the beats of one packet.
// Assumes start and upd are never both high; holds its value otherwise.
module lld_crc
    import lld_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          upd,
    input  logic [DW-1:0] word,
    output logic [31:0]   crc_q
);

    // Seed and fold the first beat on start, fold further beats on upd.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= CRC_SEED;
        end else if (start) begin
            crc_q <= crc_step(CRC_SEED, word);
        end else if (upd) begin
            crc_q <= crc_step(crc_q, word);
        end
    end

endmodule

// File: rtl/lld_pbuf.sv
// Packet buffer: stores payload words until the verdict, then drains them.
// Assumes commit arrives only while not draining, and that writes stop during a drain.
module lld_pbuf #(
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          commit,
    output logic          ovf,
    output logic          busy,
    output logic          out_valid,
    output logic          out_sop,
    output logic          out_eop,
    output logic [DW-1:0] out_data
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];
    logic [CW-1:0] cnt;
    logic [CW-1:0] rd;
    logic          draining;

    // Payload storage, written in arrival order.
    always_ff @(posedge clk) begin
        if (wr && (cnt != CW'(DEPTH))) begin
            mem[cnt[AW-1:0]] <= wdata;
        end
    end

    // Fill count and overflow flag, both cleared at the start of each packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (clr) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (wr) begin
            if (cnt == CW'(DEPTH)) ovf <= 1'b1;
            else                   cnt <= cnt + CW'(1);
        end
    end

    // Drain sequencer: one word per cycle from commit until the last stored word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            draining <= 1'b0;
            rd       <= '0;
        end else if (commit) begin
            draining <= (cnt != '0);
            rd       <= '0;
        end else if (draining) begin
            if (rd == cnt - CW'(1)) draining <= 1'b0;
            else                    rd       <= rd + CW'(1);
        end
    end

    assign busy      = draining;
    assign out_valid = draining;
    assign out_sop   = draining && (rd == '0);
    assign out_eop   = draining && (rd == cnt - CW'(1));
    assign out_data  = mem[rd[AW-1:0]];

    // R1
    commit_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && (cnt != '0)) |=> (out_valid && out_sop));
    // R1
    eop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eop) |=> !out_valid);
    // R9
    empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && (cnt == '0)) |=> !out_valid);
    // R8
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf);

endmodule

// File: rtl/lld_seq.sv
// Sequence tracker: classifies each finished packet and issues ACK/NAK requests.
// Assumes judge is a one-cycle pulse on the last beat of a packet.
module lld_seq
    import lld_pkg::*;
#(
    parameter int SEQ_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             judge,
    input  logic             crc_ok,
    input  logic [SEQ_W-1:0] rx_seq,
    output logic             good,
    output logic             ack_valid,
    output logic             ack_is_nak,
    output logic [SEQ_W-1:0] ack_seq
);

    logic [SEQ_W-1:0] exp_q;
    logic             nak_off;
    logic [SEQ_W-1:0] back;
    logic [SEQ_W-1:0] last_good;
    verdict_t         ver;

    assign back      = exp_q - rx_seq;
    assign last_good = exp_q - SEQ_W'(1);

    // Classify the packet: exact match is good, a recent older number is a duplicate.
    always_comb begin
        if (!crc_ok)                                 ver = VER_BAD;
        else if (rx_seq == exp_q)                    ver = VER_GOOD;
        else if (!back[SEQ_W-1] && (back != '0))     ver = VER_DUP;
        else                                         ver = VER_BAD;
    end

    assign good = judge && (ver == VER_GOOD);

    // Expected number and NAK arming update on each verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q   <= '0;
            nak_off <= 1'b0;
        end else if (judge) begin
            if (ver == VER_GOOD) begin
                exp_q   <= exp_q + SEQ_W'(1);
                nak_off <= 1'b0;
            end else if (ver == VER_BAD) begin
                nak_off <= 1'b1;
            end
        end
    end

    // Acknowledgement request register, one cycle per verdict that needs a reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid  <= 1'b0;
            ack_is_nak <= 1'b0;
            ack_seq    <= '0;
        end else begin
            ack_valid <= 1'b0;
            if (judge) begin
                case (ver)
                    VER_GOOD: begin
                        ack_valid  <= 1'b1;
                        ack_is_nak <= 1'b0;
                        ack_seq    <= rx_seq;
                    end
                    VER_DUP: begin
                        ack_valid  <= 1'b1;
                        ack_is_nak <= 1'b0;
                        ack_seq    <= last_good;
                    end
                    default: begin
                        ack_valid  <= !nak_off;
                        ack_is_nak <= 1'b1;
                        ack_seq    <= last_good;
                    end
                endcase
            end
        end
    end

    // R2
    exp_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        good |=> (exp_q == $past(exp_q) + SEQ_W'(1)));
    // R3
    exp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (judge && !good) |=> $stable(exp_q));
    // R5
    nak_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (judge && nak_off && (ver == VER_BAD)) |=> !ack_valid);
    // R2
    ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(judge));

endmodule

// File: rtl/lld_rx_check.sv
// Link receive sequence checker top: frames beats into packets, checks CRC
// and sequence, buffers payload and forwards it only for good packets.
// Assumes 32-bit beats; sequence in the low SEQ_W bits of the first beat.
module lld_rx_check
    import lld_pkg::*;
#(
    parameter int SEQ_W   = 12,
    parameter int MAX_PAY = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic [31:0]      in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic             out_sop,
    output logic             out_eop,
    output logic [31:0]      out_data,
    output logic             ack_valid,
    output logic             ack_is_nak,
    output logic [SEQ_W-1:0] ack_seq
);

    logic             beat, first, mid, last;
    logic             in_pkt;
    logic [SEQ_W-1:0] seq_q;
    logic [SEQ_W-1:0] rx_seq;
    logic [31:0]      crc_q;
    logic             ovf, busy, crc_ok, good;

    assign beat  = in_valid && in_ready;
    assign first = beat && in_sop;
    assign mid   = beat && !in_sop && !in_eop && in_pkt;
    assign last  = beat && in_eop && (in_sop || in_pkt);

    // Packet framing: remember that a packet is open and its sequence number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pkt <= 1'b0;
            seq_q  <= '0;
        end else if (beat) begin
            if (in_sop) seq_q <= in_data[SEQ_W-1:0];
            if (in_eop)      in_pkt <= 1'b0;
            else if (in_sop) in_pkt <= 1'b1;
        end
    end

    assign rx_seq   = in_sop ? in_data[SEQ_W-1:0] : seq_q;
    assign crc_ok   = !in_sop && (~crc_q == in_data) && !ovf;
    assign in_ready = !busy;

    lld_crc u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .start (first),
        .upd   (mid),
        .word  (in_data),
        .crc_q (crc_q)
    );

    lld_pbuf #(.DW(32), .DEPTH(MAX_PAY)) u_pbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (first),
        .wr        (mid),
        .wdata     (in_data),
        .commit    (good),
        .ovf       (ovf),
        .busy      (busy),
        .out_valid (out_valid),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .out_data  (out_data)
    );

    lld_seq #(.SEQ_W(SEQ_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .judge      (last),
        .crc_ok     (crc_ok),
        .rx_seq     (rx_seq),
        .good       (good),
        .ack_valid  (ack_valid),
        .ack_is_nak (ack_is_nak),
        .ack_seq    (ack_seq)
    );

    // R8
    single_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last && in_sop) |=> (!out_valid && !(ack_valid && !ack_is_nak)));
    // R3
    bad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !crc_ok) |=> !out_valid);

endmodule

// File: tb/lld_rx_check_tb.sv
module lld_rx_check_tb;

    localparam int MAXP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready, out_valid, out_sop, out_eop;
    logic [31:0] out_data;
    logic        ack_valid, ack_is_nak;
    logic [11:0] ack_seq;

    always #4 clk = ~clk;

    lld_rx_check #(.SEQ_W(12), .MAX_PAY(MAXP)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
        .in_ready(in_ready),
        .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data),
        .ack_valid(ack_valid), .ack_is_nak(ack_is_nak), .ack_seq(ack_seq)
    );

    int errs = 0;
    int checks = 0;
    logic [33:0] exp_out[$];
    logic [12:0] exp_ack[$];
    logic [31:0] pkt_w[$];
    int  exp_m = 0;
    bit  nak_m = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Bytewise CRC-32 over pkt_w, result inverted.
    function automatic logic [31:0] crc_ref();
        logic [31:0] c = 32'hFFFF_FFFF;
        foreach (pkt_w[k]) begin
            for (int b = 0; b < 4; b++) begin
                c = c ^ {24'h0, pkt_w[k][8*b +: 8]};
                for (int j = 0; j < 8; j++)
                    c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
            end
        end
        return ~c;
    endfunction

    task automatic drive_beat(input logic [31:0] w, input bit s, input bit e);
        @(posedge clk); #1;
        in_valid = 1'b0;
        while (!in_ready) begin @(posedge clk); #1; end
        in_valid = 1'b1; in_sop = s; in_eop = e; in_data = w;
    endtask

    task automatic send(input int seq, input int npay, input bit bad_crc, input bit single);
        logic [31:0] crc;
        int  fwd, back, total;
        bit  ok, want_ack, want_out;
        pkt_w.delete();
        pkt_w.push_back({20'hABCDE, 12'(seq)});
        for (int i = 0; i < npay; i++) pkt_w.push_back(32'h5000_0000 + (seq << 8) + i);
        crc = crc_ref();
        if (bad_crc) crc = crc ^ 32'h0000_0100;
        fwd  = (seq - exp_m) & 4095;
        back = (exp_m - seq) & 4095;
        ok   = !bad_crc && !single && (npay <= MAXP);
        want_ack = 1'b1; want_out = 1'b0;
        if (ok && fwd == 0) begin
            for (int i = 0; i < npay; i++)
                exp_out.push_back({(i == 0), (i == npay - 1), pkt_w[i + 1]});
            exp_ack.push_back({1'b0, 12'(seq)});
            exp_m = (exp_m + 1) & 4095; nak_m = 0;
            want_out = (npay > 0);
        end else if (ok && back != 0 && back < 2048) begin
            exp_ack.push_back({1'b0, 12'((exp_m - 1) & 4095)});
        end else if (!nak_m) begin
            exp_ack.push_back({1'b1, 12'((exp_m - 1) & 4095)});
            nak_m = 1;
        end else begin
            want_ack = 1'b0;
        end
        total = single ? 1 : npay + 2;
        for (int i = 0; i < total; i++) begin
            if (i == 0)              drive_beat(pkt_w[0], 1'b1, (total == 1));
            else if (i == total - 1) drive_beat(crc, 1'b0, 1'b1);
            else                     drive_beat(pkt_w[i], 1'b0, 1'b0);
        end
        @(posedge clk); #1; in_valid = 1'b0;
        @(negedge clk);
        // R2 R3 R5: the request appears in the cycle after the last beat
        chk(ack_valid == want_ack, "R2", "ack timing", 64'(ack_valid), 64'(want_ack));
        // R1 R9: payload starts in the cycle after the last beat
        chk(out_valid == want_out, "R1", "out timing", 64'(out_valid), 64'(want_out));
        repeat (npay + 2) @(posedge clk);
    endtask

    // Per-clock comparison against the model queues.
    always @(negedge clk) begin
        if (rst_n) begin
            if (ack_valid) begin
                if (exp_ack.size() == 0) begin
                    chk(1'b0, "R5", "unexpected ack", {51'h0, ack_is_nak, ack_seq}, 64'h0);
                end else begin
                    logic [12:0] e;
                    e = exp_ack.pop_front();
                    chk({ack_is_nak, ack_seq} == e, "R2", "ack nak/seq",
                        {51'h0, ack_is_nak, ack_seq}, {51'h0, e});
                end
            end
            if (out_valid) begin
                // R7: no input taken while draining
                chk(!in_ready, "R7", "in_ready during drain", 64'(in_ready), 64'h0);
                if (exp_out.size() == 0) begin
                    chk(1'b0, "R3", "unexpected output", {32'h0, out_data}, 64'h0);
                end else begin
                    logic [33:0] e;
                    e = exp_out.pop_front();
                    chk({out_sop, out_eop, out_data} == e, "R1", "out word",
                        {30'h0, out_sop, out_eop, out_data}, {30'h0, e});
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired", 64'h0, 64'h1);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R6: idle outputs during reset
        chk(!out_valid, "R6", "out_valid in reset", 64'(out_valid), 64'h0);
        chk(!ack_valid, "R6", "ack_valid in reset", 64'(ack_valid), 64'h0);
        chk(in_ready,   "R6", "in_ready in reset",  64'(in_ready), 64'h1);
        @(posedge clk); #1 rst_n = 1'b1;

        send(0, 2, 1, 0);      // R6 R3: first NAK names 4095
        send(0, 3, 0, 0);      // R1 R2: good packet, rearm
        send(1, 1, 0, 0);      // R2
        send(2, 0, 0, 0);      // R9: empty payload
        send(1, 2, 0, 0);      // R4: duplicate re-ACKed with 2
        send(3, 1, 1, 0);      // R3: bad CRC -> NAK 2
        send(4, 1, 0, 0);      // R5: ahead, NAK suppressed
        send(3, 2, 1, 0);      // R5: still suppressed
        send(3, MAXP, 0, 0);   // R5: good rearms; full buffer
        send(5, 1, 0, 0);      // R4: ahead -> NAK 3
        send(4, 2, 0, 0);      // R2
        send(5, MAXP + 1, 0, 0); // R8: overflow -> NAK 4
        send(5, 1, 0, 0);      // R2
        send(6, 0, 0, 1);      // R8: single beat -> NAK 5
        for (int s = 6; s < 4096; s++) send(s, 0, 0, 0);
        send(0, 2, 0, 0);      // R2: wrap to 0
        send(4095, 1, 0, 0);   // R4: duplicate across wrap -> ACK 0
        repeat (4) @(posedge clk);
        chk(exp_ack.size() == 0, "R2", "acks outstanding", 64'(exp_ack.size()), 64'h0);
        chk(exp_out.size() == 0, "R1", "words outstanding", 64'(exp_out.size()), 64'h0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule